// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns parallel words into a serial bit stream. A word written through the write port goes into a holding register. At the start of a frame, the holding register is copied into a shift register. The shift register then drives one bit onto the data output per bit-clock tick.

The bit clock does not reach the block as a clock. It arrives as two single-cycle enable pulses, one for each bit-clock edge. A configuration bit picks which of the two edges drives data.

The element length is selected at run time from six sizes. A reversal option sends full 32-bit words least significant bit first. A frame starts in one of three ways:
- the block makes its own frame sync each time a word is copied,
- it follows a frame pulse from a sample rate generator, or
- it waits for a frame sync on an external pin.

The frame sync polarity is programmable, and the data always follows the frame sync with a one-bit delay. If a frame starts with no fresh word pending, the last word is sent again and an underrun flag is raised.

Top module: `frame_tx`

## Requirements
- R1: After reset, `wr_ready` is 1, `dout` is 0, `underrun` is 0 and `fs_out` sits at its inactive level (equal to `cfg_fs_low`).
- R2: `cfg_len` selects the element length: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32 bits; 6 and 7 also mean 32. Only the low (length) bits of the written word are sent. They go most significant bit first, one bit per drive tick.
- R3: With `cfg_rev`=1 and a 32-bit length, the word is sent least significant bit first. For any other length `cfg_rev` has no effect.
- R4: With `cfg_fs_int`=1 and `cfg_fs_copy`=1, `fs_out` is active for exactly the one tick period that starts at the tick that copies a word. The first data bit appears at the next drive tick.
- R5: `wr_ready` drops the cycle after an accepted write and rises after the tick that copies the word into the shift register. A write while `wr_ready` is 0 is ignored.
- R6: With `cfg_fs_int`=1 and `cfg_fs_copy`=0, `fs_out` follows `gen_fs` as sampled at each drive tick. A frame starts on a tick where `gen_fs` is 1, and no frame starts without it.
- R7: With `cfg_fs_int`=0, `fs_oe` is 0 and `fs_out` stays inactive. `fs_in` is sampled at drive ticks, and the first bit follows the active sample by one tick. No frame starts while `fs_in` is inactive.
- R8: `cfg_fs_low`=1 makes the frame sync active low, both on `fs_out` and on `fs_in`.
- R9: `cfg_clk_fall`=1 makes `bclk_fall` the drive tick, and `cfg_clk_fall`=0 makes it `bclk_rise`. Pulses on the other edge input change no output.
- R10: A frame start with no pending word resends the last copied word and sets `underrun`. The next accepted write clears it.
- R11: A frame start on the tick that sends the last bit of a word is accepted, so words follow with no gap. Frame syncs that arrive earlier in a word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 3 | Element length select |
| cfg_rev | input | 1 | LSB-first reversal for 32-bit words |
| cfg_fs_int | input | 1 | 1: frame sync made inside and driven out; 0: taken from `fs_in` |
| cfg_fs_copy | input | 1 | Internal source: 1 on each copy, 0 follow `gen_fs` |
| cfg_fs_low | input | 1 | Frame sync active low |
| cfg_clk_fall | input | 1 | Drive data on the falling bit-clock edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to send |
| wr_ready | output | 1 | Holding register empty |
| bclk_rise | input | 1 | Rising bit-clock edge pulse |
| bclk_fall | input | 1 | Falling bit-clock edge pulse |
| gen_fs | input | 1 | Sample rate generator frame pulse (active high) |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Driven frame sync |
| fs_oe | output | 1 | Frame sync output enable |
| dout | output | 1 | Serial data |
| underrun | output | 1 | Frame started with no pending word |

## Verification
The bench builds the block with its default 32-bit word width. That width is the only one at which all six element lengths and the reversal option are legal, so every length and every bit order can be reached from the run-time select. Seeded random words and lengths run through the copy-driven mode. Directed cases cover the generator-driven and external-sync modes with both polarities, the falling-edge drive setting, gapless back-to-back words, mid-word syncs and underrun.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // element length in bits for a length select code
  function automatic logic [CNT_W-1:0] elem_len(input logic [2:0] sel);
    case (sel)
      3'd0:    elem_len = CNT_W'(8);
      3'd1:    elem_len = CNT_W'(12);
      3'd2:    elem_len = CNT_W'(16);
      3'd3:    elem_len = CNT_W'(20);
      3'd4:    elem_len = CNT_W'(24);
      default: elem_len = CNT_W'(WORD_W);
    endcase
  endfunction

  // put the first bit to send at the top of the word
  function automatic logic [WORD_W-1:0] stage_word(input logic [WORD_W-1:0] w,
                                                   input logic [2:0] sel,
                                                   input logic rev);
    logic [CNT_W-1:0]  n;
    logic [WORD_W-1:0] r;
    n = elem_len(sel);
    r = '0;
    if (rev && (n == CNT_W'(WORD_W))) begin
      for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    end else begin
      r = w << (WORD_W - int'(n));
    end
    return r;
  endfunction
endpackage

// File: rtl/ftx_hold.sv
module ftx_hold
  import frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              wr_acc
);
  assign wr_acc = wr_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (wr_acc) begin
      full <= 1'b1;
      word <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> full);
  a_r5_copy_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full) |=> !full);
  a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(word));
endmodule

// File: rtl/ftx_sync.sv
module ftx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cfg_fs_int,
  input  logic cfg_fs_copy,
  input  logic cfg_fs_low,
  input  logic gen_fs,
  input  logic fs_in,
  input  logic hold_full,
  input  logic slot_free,
  output logic frame_ev,
  output logic fs_out,
  output logic fs_oe
);
  logic fs_in_act;
  logic req;
  logic fs_act_q;

  assign fs_in_act = fs_in ^ cfg_fs_low;

  always_comb begin
    if (!cfg_fs_int)     req = fs_in_act;
    else if (cfg_fs_copy) req = hold_full;
    else                 req = gen_fs;
  end

  assign frame_ev = tick && slot_free && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fs_act_q <= 1'b0;
    else if (tick) fs_act_q <= cfg_fs_int && (cfg_fs_copy ? (slot_free && hold_full) : gen_fs);
  end

  assign fs_out = fs_act_q ^ cfg_fs_low;
  assign fs_oe  = cfg_fs_int;

  a_r4_copy_sync_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ev && cfg_fs_int && cfg_fs_copy) |=> (fs_out != cfg_fs_low));
  a_r9_sync_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fs_act_q));
endmodule

// File: rtl/ftx_shift.sv
module ftx_shift
  import frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len,
  output logic              slot_free,
  output logic              dout
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dout_q;

  assign slot_free = (cnt_q <= CNT_W'(1));
  assign dout      = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      dout_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q != '0) dout_q <= sh_q[WORD_W-1];
      if (load) begin
        sh_q  <= load_word;
        cnt_q <= load_len;
      end else if (cnt_q != '0) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r9_quiet_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout));
  a_r11_no_mid_word_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q <= CNT_W'(1)));
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len >= CNT_W'(8)));
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_rev,
  input  logic              cfg_fs_int,
  input  logic              cfg_fs_copy,
  input  logic              cfg_fs_low,
  input  logic              cfg_clk_fall,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              gen_fs,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  output logic              dout,
  output logic              underrun
);
  logic              tick;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic              wr_acc;
  logic              slot_free;
  logic              frame_ev;
  logic              load_new;
  logic              starve_ev;
  logic [WORD_W-1:0] staged;
  logic              underrun_q;

  assign tick      = cfg_clk_fall ? bclk_fall : bclk_rise;
  assign load_new  = frame_ev && hold_full;
  assign starve_ev = frame_ev && !hold_full;
  assign staged    = stage_word(hold_word, cfg_len, cfg_rev);
  assign wr_ready  = !hold_full;
  assign underrun  = underrun_q;

  ftx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load_new), .full(hold_full), .word(hold_word), .wr_acc(wr_acc)
  );

  ftx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_fs_int(cfg_fs_int),
    .cfg_fs_copy(cfg_fs_copy), .cfg_fs_low(cfg_fs_low), .gen_fs(gen_fs),
    .fs_in(fs_in), .hold_full(hold_full), .slot_free(slot_free),
    .frame_ev(frame_ev), .fs_out(fs_out), .fs_oe(fs_oe)
  );

  ftx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(frame_ev),
    .load_word(staged), .load_len(elem_len(cfg_len)),
    .slot_free(slot_free), .dout(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         underrun_q <= 1'b0;
    else if (wr_acc)    underrun_q <= 1'b0;
    else if (starve_ev) underrun_q <= 1'b1;
  end

  a_r10_starve_flags: assert property (@(posedge clk) disable iff (!rst_n)
    starve_ev |=> underrun);
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ready) |=> !underrun);
  a_r5_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    load_new |=> wr_ready);
endmodule

// File: tb/test_frame_tx.sv
module test_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_len = 3'd5;
  logic        cfg_rev = 1'b0, cfg_fs_int = 1'b1, cfg_fs_copy = 1'b1;
  logic        cfg_fs_low = 1'b0, cfg_clk_fall = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bclk_rise = 1'b0, bclk_fall = 1'b0, gen_fs = 1'b0, fs_in = 1'b0;
  logic        wr_ready, fs_out, fs_oe, dout, underrun;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  frame_tx i_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rev(cfg_rev),
    .cfg_fs_int(cfg_fs_int), .cfg_fs_copy(cfg_fs_copy), .cfg_fs_low(cfg_fs_low),
    .cfg_clk_fall(cfg_clk_fall), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .gen_fs(gen_fs), .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe),
    .dout(dout), .underrun(underrun)
  );

  function automatic int exp_len(input logic [2:0] sel);
    return (sel >= 3'd5) ? 32 : 8 + 4 * int'(sel);
  endfunction

  // expected bits in send order: index 0 is the first bit on the wire
  function automatic logic [31:0] exp_vec(input logic [31:0] w, input logic [2:0] sel,
                                          input logic rev);
    logic [31:0] v;
    int n;
    v = '0;
    n = exp_len(sel);
    for (int i = 0; i < n; i++) v[i] = (rev && n == 32) ? w[i] : w[n-1-i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cfg_clk_fall) bclk_fall = 1'b1; else bclk_rise = 1'b1;
    @(negedge clk);
    bclk_fall = 1'b0;
    bclk_rise = 1'b0;
  endtask

  task automatic wrong_edge();
    @(negedge clk);
    if (cfg_clk_fall) bclk_rise = 1'b1; else bclk_fall = 1'b1;
    @(negedge clk);
    bclk_fall = 1'b0;
    bclk_rise = 1'b0;
  endtask

  task automatic write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // receive n bits; at bit index mid the external sync is pulsed active
  task automatic capture(input int n, input int mid, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      if (i == mid) fs_in = ~cfg_fs_low;
      tick();
      fs_in = cfg_fs_low;
      got[i] = dout;
    end
  endtask

  task automatic frame_copy(input logic [31:0] w, input logic [2:0] sel,
                            input logic rev, input string req);
    logic [31:0] got;
    cfg_len = sel;
    cfg_rev = rev;
    write(w);
    chk(!wr_ready, "R5", {31'd0, wr_ready}, 32'd0);
    tick();
    chk(fs_out == ~cfg_fs_low && wr_ready, "R4", {30'd0, fs_out, wr_ready},
        {30'd0, ~cfg_fs_low, 1'b1});
    capture(exp_len(sel), -1, got);
    chk(got == exp_vec(w, sel, rev), req, got, exp_vec(w, sel, rev));
    chk(fs_out == cfg_fs_low, "R4", {31'd0, fs_out}, {31'd0, cfg_fs_low});
  endtask

  initial begin
    logic [31:0] got, w1, w2, seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready && !dout && !underrun && fs_out == 1'b0, "R1",
        {28'd0, wr_ready, dout, underrun, fs_out}, 32'h8);

    // R2 each length, MSB first, copy-driven sync
    for (int s = 0; s < 8; s++) frame_copy($urandom, 3'(s), 1'b0, "R2");
    // R3 reversal at 32 and no effect at 24
    frame_copy(32'h8000_0001, 3'd5, 1'b1, "R3");
    frame_copy($urandom, 3'd5, 1'b1, "R3");
    frame_copy($urandom, 3'd4, 1'b1, "R3");
    // R5 write while full ignored
    cfg_len = 3'd2; cfg_rev = 1'b0;
    write(32'h0000_A5C3);
    write(32'h0000_FFFF);
    tick();
    capture(16, -1, got);
    chk(got == exp_vec(32'h0000_A5C3, 3'd2, 1'b0), "R5", got,
        exp_vec(32'h0000_A5C3, 3'd2, 1'b0));
    // R8 copy mode active low
    cfg_fs_low = 1'b1;
    frame_copy($urandom, 3'd1, 1'b0, "R8");
    cfg_fs_low = 1'b0;

    // R11 back to back, gapless
    cfg_len = 3'd0;
    w1 = $urandom; w2 = $urandom;
    write(w1);
    tick();
    write(w2);
    capture(8, -1, got);
    chk(fs_out == 1'b1 && !wr_ready == 1'b0, "R11", {31'd0, fs_out}, 32'd1);
    chk(got == exp_vec(w1, 3'd0, 1'b0), "R11", got, exp_vec(w1, 3'd0, 1'b0));
    capture(8, -1, got);
    chk(got == exp_vec(w2, 3'd0, 1'b0), "R11", got, exp_vec(w2, 3'd0, 1'b0));

    // R9 falling edge drives, rising pulses do nothing
    cfg_clk_fall = 1'b1;
    cfg_len = 3'd3;
    w1 = $urandom;
    write(w1);
    repeat (3) wrong_edge();
    chk(!wr_ready && fs_out == 1'b0, "R9", {30'd0, wr_ready, fs_out}, 32'd0);
    tick();
    chk(wr_ready && fs_out, "R9", {30'd0, wr_ready, fs_out}, 32'd3);
    got = '0;
    for (int i = 0; i < 20; i++) begin
      logic held;
      tick();
      got[i] = dout;
      held = dout;
      wrong_edge();
      if (i == 5) chk(dout == held, "R9", {31'd0, dout}, {31'd0, held});
    end
    chk(got == exp_vec(w1, 3'd3, 1'b0), "R9", got, exp_vec(w1, 3'd3, 1'b0));
    cfg_clk_fall = 1'b0;

    // R6 follow generator pulse
    cfg_fs_copy = 1'b0;
    cfg_len = 3'd2;
    w1 = $urandom;
    write(w1);
    tick(); tick();
    chk(!wr_ready && fs_out == 1'b0, "R6", {30'd0, wr_ready, fs_out}, 32'd0);
    gen_fs = 1'b1;
    tick();
    gen_fs = 1'b0;
    chk(wr_ready && fs_out, "R6", {30'd0, wr_ready, fs_out}, 32'd3);
    capture(16, -1, got);
    chk(got == exp_vec(w1, 3'd2, 1'b0), "R6", got, exp_vec(w1, 3'd2, 1'b0));
    chk(fs_out == 1'b0, "R6", {31'd0, fs_out}, 32'd0);

    // R7 / R8 external sync, active low
    cfg_fs_int = 1'b0;
    cfg_fs_low = 1'b1;
    fs_in = 1'b1;
    cfg_len = 3'd4;
    w1 = $urandom;
    write(w1);
    tick(); tick();
    chk(!fs_oe && fs_out && !wr_ready, "R7", {29'd0, fs_oe, fs_out, wr_ready}, 32'd2);
    fs_in = 1'b0;
    tick();
    fs_in = 1'b1;
    chk(wr_ready, "R8", {31'd0, wr_ready}, 32'd1);
    capture(24, 6, got);  // R11 mid-word sync ignored
    chk(got == exp_vec(w1, 3'd4, 1'b0), "R11", got, exp_vec(w1, 3'd4, 1'b0));
    chk(fs_out == 1'b1, "R7", {31'd0, fs_out}, 32'd1);

    // R10 underrun resends last word
    fs_in = 1'b0;
    tick();
    fs_in = 1'b1;
    chk(underrun, "R10", {31'd0, underrun}, 32'd1);
    capture(24, -1, got);
    chk(got == exp_vec(w1, 3'd4, 1'b0), "R10", got, exp_vec(w1, 3'd4, 1'b0));
    w2 = $urandom;
    write(w2);
    chk(!underrun, "R10", {31'd0, underrun}, 32'd0);
    fs_in = 1'b0;
    tick();
    fs_in = 1'b1;
    capture(24, -1, got);
    chk(got == exp_vec(w2, 3'd4, 1'b0), "R7", got, exp_vec(w2, 3'd4, 1'b0));

    // random frames, copy-driven sync
    cfg_fs_int = 1'b1; cfg_fs_copy = 1'b1; cfg_fs_low = 1'b0;
    for (int k = 0; k < 24; k++)
      frame_copy($urandom, 3'($urandom % 8), 1'($urandom), "R2");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule